// File: doc/BRIEF.md
# Per-port lookup key type selector

This block decides, for every frame that enters a classifier lookup, which key layouts that lookup may build. It holds one configuration word for each combination of ingress port and lookup index. The classifier runs four lookups, grouped as two instances of two lookups each, and the lookup index 0..3 selects among them. An upstream parser supplies the port, the lookup index and a few class flags. The block turns the flags into one traffic class, takes that class's selector field from the addressed word, and decodes it into a set of eligible key types.

The result is registered. One clock after a frame is presented, a valid flag and a key type vector appear. The key type vector usually has one bit set. One selector value enables the IPv4 TCP/UDP key and the IPv4-other key together. Some encodings produce no key at all. A plain write/read port loads and inspects the configuration words. Reset gives every word a working default, so the classifier produces keys before software writes anything.

Top module: `key_type_sel`

## Requirements
- R1: After reset, result_vld_o and keys_o are 0. Every configuration word reads back 0x02493: enabled, ARP selector 1, both IPv4 selectors 1, both IPv6 selectors 1, non-IP selector 0.
- R2: A write with cfg_we_i high stores cfg_wdata_i into the word addressed by cfg_port_i/cfg_lkp_i at the next clock edge. No other word changes. cfg_rdata_o shows the addressed word combinationally. A frame presented in the same cycle as a write to its word still uses the old word.
- R3: Bit 0 of the configuration word is the enable. When the addressed word has enable 0, a frame gives result_vld_o = 0 and keys_o = 0 one clock later.
- R4: Results appear one clock after the frame is sampled. When frame_vld_i is low, the next result_vld_o is 0. Whenever result_vld_o is 0, keys_o is 0.
- R5: The keys_o bits mean the following: bit 0 MAC/EtherType, bit 1 ARP, bit 2 IPv4 TCP/UDP, bit 3 IPv4 other, bit 4 7-tuple, bit 5 standard IPv6. At most two bits are set at a time, and bits 2 and 3 are always equal.
- R6: The class is chosen by priority. ARP comes first (arp_i), then IPv4 (ip4_i), then IPv6 (ip6_i), and otherwise the frame is non-IP. For IPv4 and IPv6, mcast_i picks the multicast selector over the unicast one, and mcast_i is ignored for ARP and non-IP frames. The selector fields sit in the word as follows: ARP [3:1], IPv4 unicast [6:4], IPv4 multicast [9:7], IPv6 unicast [12:10], IPv6 multicast [15:13], non-IP [18:16].
- R7: The ARP selector decodes as follows: 0 gives the MAC/EtherType key, and 1 gives the ARP key.
- R8: Each IPv4 selector decodes as follows: 0 gives MAC/EtherType, 1 gives the IPv4 TCP/UDP and IPv4-other keys together, and 2 gives the 7-tuple key.
- R9: Each IPv6 selector decodes as follows: 0 gives MAC/EtherType, 1 gives 7-tuple, 2 gives standard IPv6, and 3 gives the IPv4 TCP/UDP and IPv4-other pair. Multicast value 4 is a VLAN-ID key, which yields no key type.
- R10: The non-IP selector decodes as follows: 0 gives the MAC/EtherType key.
- R11: Any selector value not listed in R7 to R10 gives keys_o = 0. result_vld_o is still 1 when the word is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_port_i | input | 3 | Configuration word port address |
| cfg_lkp_i | input | 2 | Configuration word lookup address |
| cfg_wdata_i | input | 19 | Configuration write data |
| cfg_rdata_o | output | 19 | Addressed configuration word |
| frame_vld_i | input | 1 | Frame class inputs are valid |
| port_i | input | 3 | Ingress port of the frame |
| lookup_i | input | 2 | Lookup index 0..3 |
| arp_i | input | 1 | Frame is ARP |
| ip4_i | input | 1 | Frame is IPv4 |
| ip6_i | input | 1 | Frame is IPv6 |
| mcast_i | input | 1 | Frame has a multicast destination |
| result_vld_o | output | 1 | Key type set is valid |
| keys_o | output | 6 | Eligible key types (bits per R5) |

## Verification
The bench sweeps all eight values of each of the six selector fields against all six frame classes. Each case uses a different port and lookup word, so a field taken from the wrong bit slice, or a class mapped to the wrong selector, gives a wrong key vector in dozens of cases. Further directed cases cover the following:
- Overlapping class flags. A priority inversion would build an IPv4 key for an ARP frame.
- The pair encoding. A decoder that sets only one bit of the pair would show up here.
- Multicast value 4 and other undefined values. A decoder that falls back to the MAC key would be caught.
- A write to a word in the same cycle as a frame that uses it. A design that bypasses the new word would change the result one cycle early.
- Readback of neighbouring words after a write, which catches an address decoder that writes several words.

// File: rtl/key_sel_pkg.sv
package key_sel_pkg;
  localparam int SEL_W    = 3;
  localparam int NUM_FLD  = 6;
  localparam int WORD_W   = 1 + NUM_FLD * SEL_W;
  localparam int NUM_KEYS = 6;

  localparam int K_MAC  = 0;
  localparam int K_ARP  = 1;
  localparam int K_V4TU = 2;
  localparam int K_V4OT = 3;
  localparam int K_7T   = 4;
  localparam int K_V6   = 5;

  // class code doubles as the selector field index within the word
  typedef enum logic [2:0] {
    CLS_ARP  = 3'd0,
    CLS_V4UC = 3'd1,
    CLS_V4MC = 3'd2,
    CLS_V6UC = 3'd3,
    CLS_V6MC = 3'd4,
    CLS_NIP  = 3'd5
  } cls_e;

  typedef logic [NUM_KEYS-1:0] keys_t;
  typedef logic [WORD_W-1:0]   word_t;

  localparam word_t CFG_DEFAULT = word_t'(19'h02493);
endpackage

// File: rtl/key_sel_cfg_regs.sv
module key_sel_cfg_regs
  import key_sel_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  word_t            wdata_i,
  output word_t            cfg_word_o,
  input  logic [IDX_W-1:0] lkp_idx_i,
  output word_t            lkp_word_o
);
  localparam int NUM_WORDS = 1 << IDX_W;

  word_t words [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : gen_word
    word_t word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  word_q <= CFG_DEFAULT;
      else if (we_i && cfg_idx_i == IDX_W'(g))      word_q <= wdata_i;
    end
    assign words[g] = word_q;
  end

  assign cfg_word_o = words[cfg_idx_i];
  assign lkp_word_o = words[lkp_idx_i];
endmodule

// File: rtl/key_sel_decode.sv
module key_sel_decode
  import key_sel_pkg::*;
(
  input  word_t word_i,
  input  logic  arp_i,
  input  logic  ip4_i,
  input  logic  ip6_i,
  input  logic  mcast_i,
  output logic  en_o,
  output keys_t keys_o
);
  cls_e             cls;
  logic [SEL_W-1:0] sel;
  keys_t            dec;

  always_comb begin
    if (arp_i)      cls = CLS_ARP;
    else if (ip4_i) cls = mcast_i ? CLS_V4MC : CLS_V4UC;
    else if (ip6_i) cls = mcast_i ? CLS_V6MC : CLS_V6UC;
    else            cls = CLS_NIP;
  end

  assign sel = word_i[1 + int'(cls) * SEL_W +: SEL_W];

  always_comb begin
    dec = '0;
    unique case (cls)
      CLS_ARP: begin
        if (sel == 3'd0)      dec[K_MAC] = 1'b1;
        else if (sel == 3'd1) dec[K_ARP] = 1'b1;
      end
      CLS_V4UC, CLS_V4MC: begin
        case (sel)
          3'd0: dec[K_MAC] = 1'b1;
          3'd1: begin dec[K_V4TU] = 1'b1; dec[K_V4OT] = 1'b1; end
          3'd2: dec[K_7T] = 1'b1;
          default: dec = '0;
        endcase
      end
      CLS_V6UC, CLS_V6MC: begin
        case (sel)
          3'd0: dec[K_MAC] = 1'b1;
          3'd1: dec[K_7T]  = 1'b1;
          3'd2: dec[K_V6]  = 1'b1;
          3'd3: begin dec[K_V4TU] = 1'b1; dec[K_V4OT] = 1'b1; end
          default: dec = '0; // includes multicast VLAN-ID key (4)
        endcase
      end
      default: begin
        if (sel == 3'd0) dec[K_MAC] = 1'b1;
      end
    endcase
  end

  assign en_o   = word_i[0];
  assign keys_o = en_o ? dec : '0;
endmodule

// File: rtl/key_type_sel.sv
module key_type_sel
  import key_sel_pkg::*;
#(
  parameter int NUM_PORTS   = 8,
  parameter int NUM_LOOKUPS = 4,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int LKP_W  = $clog2(NUM_LOOKUPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [PORT_W-1:0]   cfg_port_i,
  input  logic [LKP_W-1:0]    cfg_lkp_i,
  input  logic [WORD_W-1:0]   cfg_wdata_i,
  output logic [WORD_W-1:0]   cfg_rdata_o,
  input  logic                frame_vld_i,
  input  logic [PORT_W-1:0]   port_i,
  input  logic [LKP_W-1:0]    lookup_i,
  input  logic                arp_i,
  input  logic                ip4_i,
  input  logic                ip6_i,
  input  logic                mcast_i,
  output logic                result_vld_o,
  output logic [NUM_KEYS-1:0] keys_o
);
  localparam int IDX_W = PORT_W + LKP_W;

  word_t cur_word;
  logic  cur_en;
  keys_t cur_keys;
  logic  vld_q;
  keys_t keys_q;

  key_sel_cfg_regs #(.IDX_W(IDX_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .cfg_idx_i  ({cfg_port_i, cfg_lkp_i}),
    .wdata_i    (cfg_wdata_i),
    .cfg_word_o (cfg_rdata_o),
    .lkp_idx_i  ({port_i, lookup_i}),
    .lkp_word_o (cur_word)
  );

  key_sel_decode u_dec (
    .word_i  (cur_word),
    .arp_i   (arp_i),
    .ip4_i   (ip4_i),
    .ip6_i   (ip6_i),
    .mcast_i (mcast_i),
    .en_o    (cur_en),
    .keys_o  (cur_keys)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      keys_q <= '0;
    end else begin
      vld_q  <= frame_vld_i & cur_en;
      keys_q <= (frame_vld_i & cur_en) ? cur_keys : '0;
    end
  end

  assign result_vld_o = vld_q;
  assign keys_o       = keys_q;
endmodule

// File: rtl/key_type_sel_chk.sv
module key_type_sel_chk
  import key_sel_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                frame_vld_i,
  input logic                arp_i,
  input logic                ip4_i,
  input logic                ip6_i,
  input logic                cur_en_i,
  input logic                result_vld_o,
  input logic [NUM_KEYS-1:0] keys_o
);
  a_r3_disabled_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && !cur_en_i) |=> !result_vld_o);

  a_r4_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> !result_vld_o);

  a_r4_keys_empty_when_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_vld_o |-> keys_o == '0);

  a_r5_at_most_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(keys_o) <= 2);

  a_r8_pair_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keys_o[K_V4TU] == keys_o[K_V4OT]);

  a_r7_arp_key_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arp_i |=> !keys_o[K_ARP]);

  a_r9_v6std_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ip6_i && !arp_i && !ip4_i) |=> !keys_o[K_V6]);
endmodule

bind key_type_sel key_type_sel_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_vld_i  (frame_vld_i),
  .arp_i        (arp_i),
  .ip4_i        (ip4_i),
  .ip6_i        (ip6_i),
  .cur_en_i     (cur_en),
  .result_vld_o (result_vld_o),
  .keys_o       (keys_o)
);

// File: tb/sim_key_type_sel.sv
module sim_key_type_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_port = '0;
  logic [1:0]  cfg_lkp = '0;
  logic [18:0] cfg_wdata = '0;
  logic [18:0] cfg_rdata;
  logic        frame_vld = 1'b0;
  logic [2:0]  port = '0;
  logic [1:0]  lookup = '0;
  logic        arp = 1'b0, ip4 = 1'b0, ip6 = 1'b0, mc = 1'b0;
  logic        res_vld;
  logic [5:0]  keys;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [18:0] DEF = 19'h02493;

  always #10 clk = ~clk;

  key_type_sel u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_port_i(cfg_port),
    .cfg_lkp_i(cfg_lkp), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .frame_vld_i(frame_vld), .port_i(port), .lookup_i(lookup), .arp_i(arp),
    .ip4_i(ip4), .ip6_i(ip6), .mcast_i(mc), .result_vld_o(res_vld), .keys_o(keys)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected key set from the requirements: field index c per R6
  function automatic logic [5:0] model(logic [18:0] w, int c);
    int v;
    logic [5:0] k;
    v = int'((w >> (1 + 3 * c)) & 19'd7);
    k = '0;
    if (c == 0) begin
      if (v == 0) k = 6'b000001;
      else if (v == 1) k = 6'b000010;
    end else if (c == 1 || c == 2) begin
      if (v == 0) k = 6'b000001;
      else if (v == 1) k = 6'b001100;
      else if (v == 2) k = 6'b010000;
    end else if (c == 3 || c == 4) begin
      if (v == 0) k = 6'b000001;
      else if (v == 1) k = 6'b010000;
      else if (v == 2) k = 6'b100000;
      else if (v == 3) k = 6'b001100;
    end else begin
      if (v == 0) k = 6'b000001;
    end
    return w[0] ? k : 6'b0;
  endfunction

  task automatic wr(int p, int l, logic [18:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_port = 3'(p); cfg_lkp = 2'(l); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(int p, int l, logic [18:0] exp, string req);
    cfg_port = 3'(p); cfg_lkp = 2'(l);
    #1;
    chk(cfg_rdata == exp, req, int'(cfg_rdata), int'(exp));
  endtask

  task automatic set_cls(int c);
    arp = (c == 0);
    ip4 = (c == 1 || c == 2);
    ip6 = (c == 3 || c == 4);
    mc  = (c == 2 || c == 4 || c == 5);
  endtask

  // present one frame, sample one cycle later at the negedge
  task automatic frame(int p, int l, int c);
    @(negedge clk);
    port = 3'(p); lookup = 2'(l); set_cls(c); frame_vld = 1'b1;
    @(negedge clk);
    frame_vld = 1'b0;
  endtask

  task automatic frame_chk(int p, int l, int c, logic [18:0] w, string req);
    logic [5:0] e;
    frame(p, l, c);
    e = model(w, c);
    chk(res_vld == w[0], req, int'(res_vld), int'(w[0]));
    chk(keys == e, req, int'(keys), int'(e));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [18:0] w;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(res_vld == 1'b0 && keys == '0, "R1 outputs in reset", int'(keys), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_vld == 1'b0 && keys == '0, "R1 outputs after reset", int'(keys), 0);
    for (int p = 0; p < 8; p++)
      for (int l = 0; l < 4; l++)
        rd_chk(p, l, DEF, "R1 default word");

    // R1 default decode per class: ARP key, pair, 7-tuple, MAC
    for (int c = 0; c < 6; c++) frame_chk(c, c % 4, c, DEF, "R1 R6 default decode");

    // R4: idle frame gives no result
    @(negedge clk); set_cls(1); frame_vld = 1'b0;
    @(negedge clk);
    chk(res_vld == 1'b0 && keys == '0, "R4 idle", int'(res_vld), 0);

    // sweep every selector value of every field against every class
    for (int f = 0; f < 6; f++)
      for (int v = 0; v < 8; v++) begin
        int p, l;
        w = DEF;
        w[1 + 3 * f +: 3] = 3'(v);
        p = (v + f) % 8;
        l = f % 4;
        wr(p, l, w);
        rd_chk(p, l, w, "R2 readback");
        for (int c = 0; c < 6; c++) begin
          string r;
          if (c == 0)                r = "R7 ARP selector";
          else if (c == 1 || c == 2) r = "R8 IPv4 selector";
          else if (c == 3 || c == 4) r = "R9 IPv6 selector";
          else                       r = "R10 R11 non-IP selector";
          frame_chk(p, l, c, w, r);
        end
        wr(p, l, DEF);
      end

    // R9 / R11: multicast VID value 4 and unicast 4 give no key, still valid
    w = DEF; w[15:13] = 3'd4; w[12:10] = 3'd4;
    wr(5, 2, w);
    frame_chk(5, 2, 4, w, "R9 multicast VID key empty");
    chk(res_vld == 1'b1, "R11 valid with empty set", int'(res_vld), 1);
    frame_chk(5, 2, 3, w, "R11 undefined IPv6 unicast");

    // R6: flag priority, ARP over IPv4 over IPv6
    w = DEF; w[6:4] = 3'd2; w[12:10] = 3'd2; w[3:1] = 3'd0;
    wr(1, 3, w);
    @(negedge clk); port = 3'd1; lookup = 2'd3; arp = 1; ip4 = 1; ip6 = 1; mc = 0; frame_vld = 1;
    @(negedge clk); frame_vld = 0;
    chk(keys == 6'b000001, "R6 ARP priority", int'(keys), 1);
    @(negedge clk); arp = 0; ip4 = 1; ip6 = 1; frame_vld = 1;
    @(negedge clk); frame_vld = 0;
    chk(keys == 6'b010000, "R6 IPv4 over IPv6", int'(keys), 16);
    @(negedge clk); arp = 0; ip4 = 0; ip6 = 1; mc = 0; frame_vld = 1;
    @(negedge clk); frame_vld = 0;
    chk(keys == 6'b100000, "R5 R9 standard IPv6 bit", int'(keys), 32);

    // R3: enable clear
    w = DEF; w[0] = 1'b0;
    wr(6, 0, w);
    for (int c = 0; c < 6; c++) frame_chk(6, 0, c, w, "R3 disabled word");
    frame_chk(6, 1, 1, DEF, "R3 neighbour still enabled");

    // R2: isolation of neighbours
    wr(2, 1, 19'h7fffe);
    rd_chk(2, 1, 19'h7fffe, "R2 written word");
    rd_chk(2, 0, DEF, "R2 neighbour lookup untouched");
    rd_chk(2, 2, DEF, "R2 neighbour lookup untouched");
    rd_chk(3, 1, DEF, "R2 neighbour port untouched");
    wr(2, 1, DEF);

    // R2: write and frame on the same word in the same cycle use old word
    @(negedge clk);
    cfg_we = 1; cfg_port = 3'd3; cfg_lkp = 2'd1; cfg_wdata = 19'h0;
    port = 3'd3; lookup = 2'd1; set_cls(0); frame_vld = 1;
    @(negedge clk);
    cfg_we = 0; frame_vld = 0;
    chk(res_vld == 1'b1 && keys == 6'b000010, "R2 same-cycle uses old word", int'(keys), 2);
    frame_chk(3, 1, 0, 19'h0, "R2 new word after write");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule